// File: doc/BRIEF.md
# Two-Bank MSI Capture Controller

This block records message-signalled interrupts that arrive as memory writes. A write is accepted as an interrupt when its 64-bit address equals a programmed target address. The write data carries the vector number to record. The 64 vectors are split into a low bank (vectors 0 to 31) and a high bank (vectors 32 to 63). Each bank has a 32-bit status register, a 32-bit mask register and its own interrupt output.

Software sets up the block through a small word-indexed register port. It reads a capability word, turns capture and status recording on, and programs the target address as two 32-bit halves. It enables vectors through the masks. When a bank's interrupt fires, software reads that bank's status, clears one bit at a time by writing a one to it, and reads again until the status is zero. Vector allocation on the CPU side and the link that delivers the writes lie outside this block.

Top module: `msi_capture_top`

## Requirements
- R1: After reset both status banks, both masks, the control word and the target address read zero, and both interrupt outputs are low.
- R2: Register word indexes: 0 capability, 1 control, 2 target low half, 3 target high half, 4 low status, 5 high status, 6 low mask, 7 high mask. Reads are combinational. The capability word always reads 1, and writes to it have no effect.
- R3: Control bit 0 turns capture on and bit 15 turns status recording on. The control, target and mask registers read back what was last written, and control bits other than 0 and 15 read zero.
- R4: A write with msiValid high, both control bits set, address equal to {target high, target low} and data value v below 64 sets bit v mod 32 of bank v div 32 (bank 0 is low). The bit is readable after the next clock edge.
- R5: A write whose address differs from the target in any of its 64 bits leaves both status banks unchanged.
- R6: A write that arrives while either control bit 0 or control bit 15 is clear leaves both status banks unchanged.
- R7: A write whose data value is 64 or more leaves both status banks unchanged, including data whose low six bits would name a valid vector.
- R8: Writing to a status word clears each bit where the written data has a one and leaves every other bit unchanged.
- R9: If a captured vector and a clear of that same status bit fall in the same cycle, the bit ends up set.
- R10: irqLo is the OR of (low status AND low mask) and irqHi is the OR of (high status AND high mask). The two outputs are independent of each other.
- R11: The masks gate only the interrupt outputs. A masked vector is still recorded in status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| msiValid | input | 1 | An inbound memory write is present this cycle |
| msiAddr | input | 64 | Address of the inbound write |
| msiData | input | 32 | Data of the inbound write (vector number) |
| irqLo | output | 1 | Interrupt for vectors 0 to 31 |
| irqHi | output | 1 | Interrupt for vectors 32 to 63 |

## Verification
The block has a one-edge latency. A captured write, a status clear and a register write all become visible on the clock edge that ends the cycle in which they are driven. From that edge on, the status reads and both interrupt outputs carry the new value. Register reads are combinational, so they need no extra cycle. The bench drives every stimulus at the falling edge and steps one rising edge. It then sets the read index at the following falling edge and samples one nanosecond later. In this way each expected value from the bench's model is compared in the first cycle where it is due.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = 2;
  localparam int NUM_VEC   = BANK_W * NUM_BANKS;
  localparam int VEC_W     = $clog2(NUM_VEC);
  localparam int IDX_W     = $clog2(BANK_W);
  localparam int BSEL_W    = VEC_W - IDX_W;
  localparam int REG_W     = 32;
  localparam int RIDX_W    = 3;
  localparam int MSI_AW    = 64;

  localparam int STAT_IDX0 = 4;
  localparam int MASK_IDX0 = 6;

  typedef enum logic [RIDX_W-1:0] {
    REG_CAP     = 3'd0,
    REG_CTRL    = 3'd1,
    REG_BASE_LO = 3'd2,
    REG_BASE_HI = 3'd3,
    REG_STAT_LO = 3'd4,
    REG_STAT_HI = 3'd5,
    REG_MASK_LO = 3'd6,
    REG_MASK_HI = 3'd7
  } reg_idx_e;

  localparam int CTRL_CAPTURE_BIT = 0;
  localparam int CTRL_RECORD_BIT  = 15;

  // strobes from control to the status datapath
  typedef struct packed {
    logic                 setEn;
    logic [VEC_W-1:0]     setVec;
    logic [NUM_BANKS-1:0] clrEn;
    logic [BANK_W-1:0]    clrMask;
  } strobe_t;
endpackage

// File: rtl/msi_ctrl.sv
module msi_ctrl
  import msi_cap_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              regWe,
  input  logic [RIDX_W-1:0]                 regAddr,
  input  logic [REG_W-1:0]                  regWdata,
  output logic [REG_W-1:0]                  regRdata,
  input  logic                              msiValid,
  input  logic [MSI_AW-1:0]                 msiAddr,
  input  logic [REG_W-1:0]                  msiData,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]  statusIn,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  maskOut,
  output strobe_t                           strb
);
  logic             captureEn, recordEn;
  logic [REG_W-1:0] baseLo, baseHi;
  logic             addrHit, dataInRange;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      captureEn <= 1'b0;
      recordEn  <= 1'b0;
      baseLo    <= '0;
      baseHi    <= '0;
    end else if (regWe) begin
      if (regAddr == REG_CTRL) begin
        captureEn <= regWdata[CTRL_CAPTURE_BIT];
        recordEn  <= regWdata[CTRL_RECORD_BIT];
      end
      if (regAddr == REG_BASE_LO) baseLo <= regWdata;
      if (regAddr == REG_BASE_HI) baseHi <= regWdata;
    end
  end

  // per-bank mask registers and status clear strobes
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] maskQ;
    always_ff @(posedge clk) begin
      if (!rstN)
        maskQ <= '0;
      else if (regWe && regAddr == RIDX_W'(MASK_IDX0 + b))
        maskQ <= regWdata[BANK_W-1:0];
    end
    assign maskOut[b]    = maskQ;
    assign strb.clrEn[b] = regWe && (regAddr == RIDX_W'(STAT_IDX0 + b));
  end

  assign strb.clrMask = regWdata[BANK_W-1:0];

  // inbound write qualification
  assign addrHit     = (msiAddr == {baseHi, baseLo});
  assign dataInRange = (msiData[REG_W-1:VEC_W] == '0);
  assign strb.setEn  = msiValid && captureEn && recordEn && addrHit && dataInRange;
  assign strb.setVec = msiData[VEC_W-1:0];

  // read mux
  always_comb begin
    regRdata = '0;
    case (regAddr)
      REG_CAP:     regRdata = 32'h1;
      REG_CTRL: begin
        regRdata[CTRL_CAPTURE_BIT] = captureEn;
        regRdata[CTRL_RECORD_BIT]  = recordEn;
      end
      REG_BASE_LO: regRdata = baseLo;
      REG_BASE_HI: regRdata = baseHi;
      REG_STAT_LO: regRdata = statusIn[0];
      REG_STAT_HI: regRdata = statusIn[1];
      REG_MASK_LO: regRdata = maskOut[0];
      REG_MASK_HI: regRdata = maskOut[1];
      default:     regRdata = '0;
    endcase
  end

  // R3: target address halves hold unless written
  a_r3_base_lo_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == REG_BASE_LO) |=> $stable(baseLo));
  a_r3_base_hi_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == REG_BASE_HI) |=> $stable(baseHi));
  // R2: at most one status bank cleared by one register write
  a_r2_one_clear: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.clrEn));
endmodule

// File: rtl/msi_status_dp.sv
module msi_status_dp
  import msi_cap_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  strobe_t                           strb,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]  maskIn,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  statusQ,
  output logic [NUM_BANKS-1:0]              irq
);
  logic [NUM_VEC-1:0] flatStatus;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] bankQ, setOne, clrBits, bankNext;
    logic              hitBank;

    assign hitBank = strb.setEn && (strb.setVec[VEC_W-1:IDX_W] == BSEL_W'(b));

    always_comb begin
      setOne = '0;
      if (hitBank) setOne[strb.setVec[IDX_W-1:0]] = 1'b1;
      clrBits  = strb.clrEn[b] ? strb.clrMask : '0;
      bankNext = (bankQ & ~clrBits) | setOne;   // set wins
    end

    always_ff @(posedge clk) begin
      if (!rstN) bankQ <= '0;
      else       bankQ <= bankNext;
    end

    assign statusQ[b] = bankQ;
    assign irq[b]     = |(bankQ & maskIn[b]);

    // R8: bits written with one are clear afterwards unless a set hit this bank
    a_r8_clear_lands: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clrEn[b] && !hitBank) |=> ((bankQ & $past(strb.clrMask)) == '0));
  end

  assign flatStatus = statusQ;

  // R4 / R9: an accepted vector is always recorded, even against a clear
  a_r4_set_lands: assert property (@(posedge clk) disable iff (!rstN)
    strb.setEn |=> flatStatus[$past(strb.setVec)]);
  // R5: no status bit appears without an accepted write
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !strb.setEn |=> ((flatStatus & ~$past(flatStatus)) == '0));
endmodule

// File: rtl/msi_capture_top.sv
module msi_capture_top
  import msi_cap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [RIDX_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  input  logic                 msiValid,
  input  logic [MSI_AW-1:0]    msiAddr,
  input  logic [REG_W-1:0]     msiData,
  output logic                 irqLo,
  output logic                 irqHi
);
  strobe_t                          strb;
  logic [NUM_BANKS-1:0][BANK_W-1:0] status, mask;
  logic [NUM_BANKS-1:0]             irq;

  msi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .msiValid(msiValid),
    .msiAddr(msiAddr), .msiData(msiData), .statusIn(status),
    .maskOut(mask), .strb(strb)
  );

  msi_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .maskIn(mask),
    .statusQ(status), .irq(irq)
  );

  assign irqLo = irq[0];
  assign irqHi = irq[1];
endmodule

// File: tb/sim_msi_capture_top.sv
module sim_msi_capture_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [2:0]  regAddr;
  logic [31:0] regWdata, regRdata;
  logic        msiValid;
  logic [63:0] msiAddr;
  logic [31:0] msiData;
  logic        irqLo, irqHi;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  logic [31:0] eStat [2];
  logic [31:0] eMask [2];
  logic        eCap, eRec;
  logic [63:0] eBase;

  always #2.5 clk = ~clk;

  msi_capture_top u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .msiValid(msiValid),
    .msiAddr(msiAddr), .msiData(msiData), .irqLo(irqLo), .irqHi(irqHi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrlWord(input logic cap, input logic rec);
    logic [31:0] w = '0;
    w[0] = cap;
    w[15] = rec;
    return w;
  endfunction

  // drive one cycle of stimulus at a falling edge, update model, step
  task automatic drive(input logic we, input logic [2:0] a, input logic [31:0] wd,
                       input logic mv, input logic [63:0] ma, input logic [31:0] md);
    logic [31:0] nStat [2];
    nStat = eStat;
    regWe = we; regAddr = a; regWdata = wd;
    msiValid = mv; msiAddr = ma; msiData = md;
    if (we && (a == 3'd4 || a == 3'd5)) nStat[a - 3'd4] &= ~wd;
    if (mv && eCap && eRec && ma == eBase && md < 64) nStat[md[5]][md[4:0]] = 1'b1;
    if (we) begin
      case (a)
        3'd1: begin eCap = wd[0]; eRec = wd[15]; end
        3'd2: eBase[31:0] = wd;
        3'd3: eBase[63:32] = wd;
        3'd6: eMask[0] = wd;
        3'd7: eMask[1] = wd;
        default: ;
      endcase
    end
    eStat = nStat;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0; msiValid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    regAddr = a;
    #1;
    check(req, regRdata, exp);
  endtask

  task automatic checkAll(input string req);
    rd(3'd4, eStat[0], req);
    rd(3'd5, eStat[1], req);
    check({req, " irqLo"}, {31'b0, irqLo}, {31'b0, |(eStat[0] & eMask[0])});
    check({req, " irqHi"}, {31'b0, irqHi}, {31'b0, |(eStat[1] & eMask[1])});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nErr++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    logic [63:0] tgt;
    int unused;
    unused = $urandom(32'd2718);
    rstN = 1'b0; regWe = 0; regAddr = 0; regWdata = 0;
    msiValid = 0; msiAddr = 0; msiData = 0;
    eStat[0] = 0; eStat[1] = 0; eMask[0] = 0; eMask[1] = 0;
    eCap = 0; eRec = 0; eBase = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, R2 capability
    for (int i = 0; i < 8; i++) rd(3'(i), (i == 0) ? 32'h1 : 32'h0, "R1 reset read");
    check("R1 irqLo reset", {31'b0, irqLo}, 32'h0);
    check("R1 irqHi reset", {31'b0, irqHi}, 32'h0);
    drive(1, 3'd0, 32'hFFFF_FFFE, 0, 0, 0);
    rd(3'd0, 32'h1, "R2 capability read-only");

    // R3 programming and readback
    tgt = 64'h0000_00AB_FEE0_1000;
    drive(1, 3'd1, 32'hFFFF_FFFF, 0, 0, 0);
    rd(3'd1, ctrlWord(1, 1), "R3 control readback");
    drive(1, 3'd2, tgt[31:0], 0, 0, 0);
    drive(1, 3'd3, tgt[63:32], 0, 0, 0);
    rd(3'd2, tgt[31:0], "R3 target low");
    rd(3'd3, tgt[63:32], "R3 target high");

    // R4 capture, R11 masked still recorded
    drive(0, 0, 0, 1, tgt, 32'd5);
    checkAll("R4 R11 vector 5");
    drive(0, 0, 0, 1, tgt, 32'd40);
    checkAll("R4 vector 40");
    drive(0, 0, 0, 1, tgt, 32'd63);
    checkAll("R4 vector 63");

    // R10 independent masks
    drive(1, 3'd6, 32'h0000_0020, 0, 0, 0);
    rd(3'd6, 32'h20, "R3 mask low readback");
    checkAll("R10 low mask only");
    drive(1, 3'd7, 32'h0000_0001, 0, 0, 0);
    checkAll("R10 high mask wrong bit");
    drive(1, 3'd7, 32'h8000_0000, 0, 0, 0);
    checkAll("R10 high mask");

    // R8 clear one bit
    drive(1, 3'd5, 32'h0000_0100, 0, 0, 0);
    checkAll("R8 clear bit 40");
    // R9 set wins against clear
    drive(1, 3'd4, 32'h0000_0020, 1, tgt, 32'd5);
    checkAll("R9 set wins");
    // R5 mismatched address high and low halves
    drive(0, 0, 0, 1, tgt ^ 64'h0000_0100_0000_0000, 32'd7);
    checkAll("R5 high-half miss");
    drive(0, 0, 0, 1, tgt ^ 64'h1, 32'd7);
    checkAll("R5 low-half miss");
    // R7 out of range data
    drive(0, 0, 0, 1, tgt, 32'd64);
    checkAll("R7 data 64");
    drive(0, 0, 0, 1, tgt, 32'h0000_0102);
    checkAll("R7 data 0x102");
    // R6 each enable off
    drive(1, 3'd1, ctrlWord(1, 0), 0, 0, 0);
    drive(0, 0, 0, 1, tgt, 32'd9);
    checkAll("R6 record off");
    drive(1, 3'd1, ctrlWord(0, 1), 0, 0, 0);
    drive(0, 0, 0, 1, tgt, 32'd9);
    checkAll("R6 capture off");
    drive(1, 3'd1, ctrlWord(1, 1), 0, 0, 0);

    // random mix, R4 R5 R7 R8 R9 R10
    for (int it = 0; it < 500; it++) begin
      logic        we, mv;
      logic [2:0]  a;
      logic [31:0] wd, md;
      logic [63:0] ma;
      we = ($urandom % 3) == 0;
      a  = 3'(4 + ($urandom % 4));
      if (($urandom % 40) == 0) a = 3'd1;
      wd = $urandom;
      if (a == 3'd1) wd = ctrlWord(($urandom % 5) != 0, ($urandom % 5) != 0);
      else if (a == 3'd4 || a == 3'd5) wd = wd & $urandom & $urandom;
      mv = ($urandom % 4) != 0;
      ma = (($urandom % 5) == 0) ? (tgt ^ (64'h1 << ($urandom % 64))) : tgt;
      md = $urandom % 72;
      drive(we, a, wd, mv, ma, md);
      checkAll("R4 R8 R10 random");
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule